// File: doc/BRIEF.md
# Interrupt Wait Poller

This block lets a host wait for a radio transceiver's interrupt line without spinning in software. The host pulses a start input with a timeout in milliseconds. From then on the block polls the level of the interrupt input once per millisecond. When a poll finds the line high, the block issues one register read of the transceiver's interrupt-status register through a request/response port toward an SPI command engine. It then returns the byte it receives. When a poll finds the line low and the deadline has already passed, the wait ends with a result of zero.

Each poll first records whether the deadline has expired and only then looks at the interrupt line. The last poll therefore takes place after the deadline, so an interrupt that arrives just as time runs out is still reported with its status. The millisecond rhythm comes from a prescaler that the clock-frequency parameter sets. The remaining time is kept in a down-counter that is loaded when a wait is accepted.

Top module: `irq_wait_poller`

## Requirements
- R1: After reset, `done_o` and `spi_req_o` are low and `status_o` is zero.
- R2: A start pulse is accepted only while no wait is in progress, and it latches `timeout_ms_i`. A start pulse during a wait has no effect on the timing or the value of that wait's result.
- R3: Let C = CLK_HZ/1000 clock cycles (minimum 3) and let edge 0 be the clock edge that accepts the start. Poll k (k = 0, 1, 2, ...) samples `irq_i` on edge k*C+2, so the first poll happens right after the start.
- R4: With a timeout of T milliseconds, the deadline flag is recorded before the interrupt line is checked on each poll, and exactly the polls k = 0..T take place. T = 0 gives a single poll.
- R5: When a poll samples `irq_i` high, `spi_req_o` rises after that edge with `spi_addr_o` equal to STATUS_ADDR (default 0x0F). It stays high until `spi_ack_i` is seen, and exactly one read is issued per wait.
- R6: On the edge that sees `spi_ack_i` high while a read is pending, the block raises `done_o` with `status_o` equal to `spi_rdata_i`.
- R7: When poll T samples `irq_i` low, `done_o` rises after edge T*C+2 with `status_o` = 0, and no read is requested.
- R8: The interrupt input is read as an active-high level. A high pulse that does not cover any poll's sampling edge is not seen.
- R9: `done_o` is high for exactly one cycle per wait.
- R10: When the deadline has passed and the final poll samples the line high, the read takes precedence and the result is the read byte, not zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a wait (ignored while busy) |
| timeout_ms_i | input | TMO_W | Timeout in milliseconds, latched at start |
| irq_i | input | 1 | Radio interrupt line, active-high level |
| done_o | output | 1 | One-cycle pulse when the wait ends |
| status_o | output | 8 | Interrupt status byte, or zero on timeout |
| spi_req_o | output | 1 | Register-read request to the SPI engine |
| spi_addr_o | output | ADDR_W | Register address of the read |
| spi_ack_i | input | 1 | Read completion from the SPI engine |
| spi_rdata_i | input | 8 | Byte returned with the acknowledge |

## Verification
The two functions that can meet in one cycle are the expiry of the deadline and the arrival of the interrupt on the final poll. The bench provokes this by raising `irq_i` exactly one cycle before edge T*C+2, and also one cycle after it. It expects the status byte in the first case and a zero result at edge T*C+2 in the second. A start pulse injected during a wait checks that a busy block keeps its original deadline.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

    localparam int STATUS_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK_TMO,
        ST_CHK_IRQ,
        ST_SLEEP,
        ST_READ
    } wait_state_e;

    typedef struct packed {
        logic                done;
        logic [STATUS_W-1:0] value;
    } wait_result_t;

    // Clock cycles in one millisecond, never below three so that a tick
    // cannot fall on the two checking states of a poll.
    function automatic int cycles_per_ms(input int clk_hz);
        return (clk_hz / 1000 < 3) ? 3 : clk_hz / 1000;
    endfunction

endpackage

// File: rtl/irqw_tick.sv
module irqw_tick #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/irqw_deadline.sv
module irqw_deadline #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMO_W-1:0] load_val,
    input  logic             dec,
    output logic             expired
);
    logic [TMO_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/irqw_ctrl.sv
module irqw_ctrl
    import irqw_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h0F
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                irq,
    input  logic                expired,
    input  logic                tick,
    output logic                accept,
    output logic                req,
    output logic [ADDR_W-1:0]   addr,
    input  logic                ack,
    input  logic [STATUS_W-1:0] rdata,
    output wait_result_t        result
);
    wait_state_e state;
    logic        tmo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            tmo_q  <= 1'b0;
            result <= '0;
        end else begin
            result.done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) state <= ST_CHK_TMO;
                end
                ST_CHK_TMO: begin
                    // deadline is recorded before the line is looked at
                    tmo_q <= expired;
                    state <= ST_CHK_IRQ;
                end
                ST_CHK_IRQ: begin
                    if (irq) begin
                        state <= ST_READ;
                    end else if (tmo_q) begin
                        result.done  <= 1'b1;
                        result.value <= '0;
                        state        <= ST_IDLE;
                    end else begin
                        state <= ST_SLEEP;
                    end
                end
                ST_SLEEP: begin
                    if (tick) state <= ST_CHK_TMO;
                end
                ST_READ: begin
                    if (ack) begin
                        result.done  <= 1'b1;
                        result.value <= rdata;
                        state        <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign accept = (state == ST_IDLE) && start;
    assign req    = (state == ST_READ);
    assign addr   = STATUS_ADDR;
endmodule

// File: rtl/irq_wait_poller.sv
module irq_wait_poller
    import irqw_pkg::*;
#(
    parameter int                CLK_HZ      = 1_000_000,
    parameter int                TMO_W       = 16,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h0F
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [TMO_W-1:0]    timeout_ms_i,
    input  logic                irq_i,
    output logic                done_o,
    output logic [STATUS_W-1:0] status_o,
    output logic                spi_req_o,
    output logic [ADDR_W-1:0]   spi_addr_o,
    input  logic                spi_ack_i,
    input  logic [STATUS_W-1:0] spi_rdata_i
);
    localparam int CYC = cycles_per_ms(CLK_HZ);

    logic         accept;
    logic         tick;
    logic         expired;
    wait_result_t result;

    irqw_tick #(.CYC(CYC)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .tick  (tick)
    );

    irqw_deadline #(.TMO_W(TMO_W)) u_deadline (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (timeout_ms_i),
        .dec      (tick),
        .expired  (expired)
    );

    irqw_ctrl #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .irq     (irq_i),
        .expired (expired),
        .tick    (tick),
        .accept  (accept),
        .req     (spi_req_o),
        .addr    (spi_addr_o),
        .ack     (spi_ack_i),
        .rdata   (spi_rdata_i),
        .result  (result)
    );

    assign done_o   = result.done;
    assign status_o = result.value;
endmodule

// File: rtl/irqw_checker.sv
module irqw_checker #(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h0F
) (
    input logic              clk,
    input logic              rst,
    input logic              done_o,
    input logic [7:0]        status_o,
    input logic              spi_req_o,
    input logic [ADDR_W-1:0] spi_addr_o,
    input logic              spi_ack_i,
    input logic [7:0]        spi_rdata_i
);
    // R5
    read_addr_chk: assert property (@(posedge clk) disable iff (rst)
        spi_req_o |-> spi_addr_o == STATUS_ADDR);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_req_o && !spi_ack_i) |=> spi_req_o);

    // R6
    ack_result_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_req_o && spi_ack_i) |=> (done_o && status_o == $past(spi_rdata_i)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    done_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !spi_req_o);
endmodule

bind irq_wait_poller irqw_checker #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .done_o      (done_o),
    .status_o    (status_o),
    .spi_req_o   (spi_req_o),
    .spi_addr_o  (spi_addr_o),
    .spi_ack_i   (spi_ack_i),
    .spi_rdata_i (spi_rdata_i)
);

// File: tb/irq_wait_poller_test.sv
module irq_wait_poller_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 8000;
    localparam int C          = 8;
    localparam int TMO_W      = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [TMO_W-1:0] timeout_ms_i = '0;
    logic             irq_i = 1'b0;
    logic             done_o;
    logic [7:0]       status_o;
    logic             spi_req_o;
    logic [7:0]       spi_addr_o;
    logic             spi_ack_i = 1'b0;
    logic [7:0]       spi_rdata_i = '0;

    int checks = 0;
    int fails  = 0;
    int rd_dly = 0;
    logic [7:0] rd_val = '0;
    int req_cnt = 0;
    int wcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_wait_poller #(.CLK_HZ(CLK_HZ), .TMO_W(TMO_W)) uut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .timeout_ms_i (timeout_ms_i),
        .irq_i        (irq_i),
        .done_o       (done_o),
        .status_o     (status_o),
        .spi_req_o    (spi_req_o),
        .spi_addr_o   (spi_addr_o),
        .spi_ack_i    (spi_ack_i),
        .spi_rdata_i  (spi_rdata_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // SPI engine model: acknowledge after rd_dly cycles of request
    always @(negedge clk) begin
        if (spi_ack_i) begin
            spi_ack_i = 1'b0;
        end else if (spi_req_o) begin
            if (wcnt == rd_dly) begin
                check(spi_addr_o == 8'h0F, "R5 read address", spi_addr_o, 15);
                spi_ack_i   = 1'b1;
                spi_rdata_i = rd_val;
                wcnt        = 0;
                req_cnt++;
            end else begin
                wcnt++;
            end
        end
    end

    // first poll index k whose sampling edge k*C+2 falls in [ron, roff)
    function automatic int exp_hit(input int t, input int ron, input int roff);
        for (int k = 0; k <= t; k++) begin
            if (k*C + 2 >= ron && k*C + 2 < roff) return k;
        end
        return -1;
    endfunction

    task automatic run_case(input int t, input int ron, input int roff, input int dly,
                            input logic [7:0] val, input int ign, input string tag);
        int hit, exp_e, got_e;
        logic [7:0] exp_v, got_v;
        hit   = exp_hit(t, ron, roff);
        exp_e = (hit >= 0) ? hit*C + 3 + dly : t*C + 2;
        exp_v = (hit >= 0) ? val : 8'h00;
        rd_dly = dly; rd_val = val; req_cnt = 0; wcnt = 0;
        got_e = -1; got_v = 8'h00;
        @(negedge clk);
        start_i = 1'b1; timeout_ms_i = TMO_W'(t);
        irq_i = (ron <= 0 && 0 < roff);
        for (int e = 0; e < 400; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (done_o) begin
                got_e = e; got_v = status_o;
                break;
            end
            start_i = (e + 1 == ign);
            timeout_ms_i = TMO_W'($urandom_range(0, 9));
            irq_i = (e + 1 >= ron && e + 1 < roff);
        end
        start_i = 1'b0; irq_i = 1'b0;
        check(got_e == exp_e, {tag, " R3 R4 R2 done edge"}, got_e, exp_e);
        check(got_v == exp_v, {tag, (hit >= 0) ? " R6 status" : " R7 zero status"}, got_v, exp_v);
        check(req_cnt == ((hit >= 0) ? 1 : 0), {tag, " R5 R7 read count"}, req_cnt, (hit >= 0) ? 1 : 0);
        @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0, {tag, " R9 single pulse"}, done_o, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0,     "R1 done low",   done_o, 0);
        check(spi_req_o == 1'b0,  "R1 req low",    spi_req_o, 0);
        check(status_o == 8'h00,  "R1 status zero", status_o, 0);
        rst = 1'b0;

        // R4 R7: zero timeout, single poll, line low
        run_case(0, 1000, 1000, 0, 8'hAA, 0, "t0_low");
        // R5 R6: zero timeout, line high from start
        run_case(0, 0, 1000, 0, 8'h5C, 0, "t0_high");
        // R10: line rises exactly for the final poll after the deadline
        run_case(3, 3*C + 2, 1000, 1, 8'h81, 0, "R10 last_poll");
        // R7: line rises one cycle too late
        run_case(3, 3*C + 3, 1000, 0, 8'h81, 0, "late_irq");
        // R8: pulse between polls is missed
        run_case(2, C + 3, 2*C + 1, 0, 8'h33, 0, "R8 gap_pulse");
        // R8: pulse covering poll 1 sampling edge is seen
        run_case(4, C + 2, C + 3, 2, 8'h44, 0, "R8 narrow_hit");
        // R2: start during the wait is ignored
        run_case(2, 1000, 1000, 0, 8'h00, C + 1, "R2 busy_start");
        // R6: status byte of zero read from the register
        run_case(1, 0, 1000, 3, 8'h00, 0, "zero_read");

        for (int i = 0; i < 40; i++) begin
            int t, ron, roff, ign;
            t    = $urandom_range(0, 4);
            ron  = $urandom_range(0, (t + 1)*C + 4);
            roff = ($urandom_range(0, 1) == 1) ? 1000 : ron + $urandom_range(1, 12);
            ign  = $urandom_range(0, 1) == 1 ? $urandom_range(1, t*C + 2) : 0;
            if (ign >= t*C + 2) ign = 0;
            run_case(t, ron, roff, $urandom_range(0, 3), 8'($urandom), ign, "rand");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule